// File: doc/BRIEF.md
# Multiplexed-Address DRAM Array Controller

This block holds a small DRAM-style storage array organised as a square grid of supercells, each supercell `DATA_W` bits wide. The default grid is 4 rows by 4 columns of 8-bit supercells, giving 16 supercells in total. A host reaches the array through one narrow address port that is shared by row and column. The port is 2 bits wide for the default grid. Every access takes two phases. A row strobe copies a complete row into an internal row buffer. Column strobes then read or modify single supercells in that buffer. A close command writes the buffer back into the array.

A refresh sequencer runs alongside the command path. A free-running timer marks a refresh as due once every `REFRESH_INTERVAL` cycles. This parameterised count stands in for a retention period of tens of milliseconds. A refresh never interrupts an open row; it waits until the row is closed. Each refresh reads one row and writes it back unchanged, taking two cycles. A row pointer steps through the rows in ascending order. The host must look at `ready_o` before it issues a row strobe.

Top module: `mux_dram_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `rdata_o` is 0, `rvalid_o` is 0, `err_o` is 0, `ready_o` is 1 and `rfsh_row_o` is 0. Every supercell holds 0.
- R2: A row strobe is accepted only when no row is open and `ready_o` is 1. When accepted, it copies row `addr_i` into the row buffer and opens that row. A row strobe issued while a row is open, or while `ready_o` is 0, is ignored.
- R3: A column strobe with `we_i`=0 while a row is open loads buffer column `addr_i` into `rdata_o` on the next cycle. On that cycle `rvalid_o` is 1, for one cycle only. `rdata_o` holds its value between reads.
- R4: A column strobe with `we_i`=1 while a row is open writes `wdata_i` into buffer column `addr_i`. It returns no data. A later read of that column in the same open row returns the written value.
- R5: A close (`pre_i`) while a row is open writes the whole buffer back into that row of the array and closes the row. A close while no row is open has no effect.
- R6: A column strobe while no row is open sets `err_o` to 1 on the next cycle, for one cycle. In that case `rvalid_o` stays 0 and `rdata_o` is unchanged.
- R7: A refresh falls due every `REFRESH_INTERVAL` cycles. While a refresh is due with no row open, or is in progress, `ready_o` is 0. A refresh lasts two cycles and leaves the stored data unchanged.
- R8: A refresh that falls due while a row is open waits, with `ready_o` held at 1, until the row is closed. It starts on the cycle after the close.
- R9: `rfsh_row_o` names the next row to refresh. It starts at 0 and advances by one, wrapping to 0 after the last row, at the end of each refresh.
- R10: When a close and a column strobe arrive in the same cycle with a row open, the close takes effect and the column strobe is dropped: no data, no error, no buffer write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_i | input | 1 | Row strobe: open row `addr_i` |
| cas_i | input | 1 | Column strobe: access column `addr_i` of the open row |
| we_i | input | 1 | With `cas_i`: 1 writes `wdata_i`, 0 reads |
| pre_i | input | 1 | Close the open row, writing the buffer back |
| addr_i | input | $clog2(SIDE) | Shared row/column address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data |
| rvalid_o | output | 1 | `rdata_o` was updated by a read |
| err_o | output | 1 | Column strobe arrived with no open row |
| ready_o | output | 1 | A row strobe may be issued |
| rfsh_row_o | output | $clog2(SIDE) | Next row to refresh |

## Verification
The bench targets four risk areas: write-back on close, the row-strobe ignore rules, refresh deferral and the close/column-strobe collision.

- Write-back is checked by changing a row through its buffer, closing it and reopening it. A design that skipped write-back, or wrote back to the wrong row, would return the old data or corrupt a neighbouring row.
- A row strobe is issued while another row is open. A design that reloaded the buffer would return the other row's contents and lose pending writes.
- A row is held open across several refresh intervals. A design that refreshed anyway would drop `ready_o` early or move `rfsh_row_o` while the row is open. A design that lost the due refresh would keep `ready_o` high after the close.
- A close and a column strobe are issued in the same cycle. A design that served the column strobe would raise `rvalid_o` or `err_o`.

A long random command stream then compares every output on every cycle against a behavioural model.

// File: rtl/mdram_pkg.sv
// Shared types for the multiplexed-address DRAM array controller.
package mdram_pkg;
    // Controller phases: closed, row open, refresh read, refresh write-back.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OPEN  = 2'd1,
        ST_RF_RD = 2'd2,
        ST_RF_WR = 2'd3
    } ctrl_state_e;
endpackage

// File: rtl/dram_cell_array.sv
// Storage array: ROWS rows of ROW_W bits each.
// The read port is combinational. The write port is one synchronous
// port that writes a whole row. Assumes a single writer per cycle.
module dram_cell_array #(
    parameter int ROWS  = 4,
    parameter int ROW_W = 32,
    localparam int AW   = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    rd_row,
    output logic [ROW_W-1:0] rd_data,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_row,
    input  logic [ROW_W-1:0] wr_data
);
    logic [ROW_W-1:0] cells_q [ROWS];

    // Row storage: cleared on reset, one row written per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) cells_q[r] <= '0;
        end else if (wr_en) begin
            cells_q[wr_row] <= wr_data;
        end
    end

    // Asynchronous row read.
    assign rd_data = cells_q[rd_row];
endmodule

// File: rtl/dram_row_buffer.sv
// Row buffer: COLS supercells of W bits each.
// It is loaded as one whole row, updated one column at a time, and
// presents both the selected column and the whole row.
// Assumes a load and a column write never occur in the same cycle.
module dram_row_buffer #(
    parameter int COLS = 4,
    parameter int W    = 8,
    localparam int AW  = $clog2(COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [COLS*W-1:0] load_data,
    input  logic              col_we,
    input  logic [AW-1:0]     col_sel,
    input  logic [W-1:0]      col_wdata,
    output logic [W-1:0]      col_rdata,
    output logic [COLS*W-1:0] row_data
);
    logic [W-1:0] slot_q [COLS];

    for (genvar c = 0; c < COLS; c++) begin : g_slot
        // One supercell slot: a row load takes priority over a column write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[c] <= '0;
            else if (load_en)
                slot_q[c] <= load_data[c*W +: W];
            else if (col_we && col_sel == AW'(c))
                slot_q[c] <= col_wdata;
        end
        assign row_data[c*W +: W] = slot_q[c];
    end

    // Column select for reads.
    assign col_rdata = slot_q[col_sel];

    // R4: a buffer write never collides with a row load.
    a_r4_load_write_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_en && col_we));
endmodule

// File: rtl/dram_refresh_timer.sv
// Refresh timer and row pointer.
// It raises a pending flag every INTERVAL cycles; start_i clears the
// flag, and a new expiry in the same cycle wins. done_i advances the
// row pointer, wrapping after ROWS-1. Assumes INTERVAL >= 2.
module dram_refresh_timer #(
    parameter int INTERVAL = 5000,
    parameter int ROWS     = 4,
    localparam int TW      = $clog2(INTERVAL),
    localparam int AW      = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          done_i,
    output logic          pend_o,
    output logic [AW-1:0] row_o
);
    logic [TW-1:0] tick_q;
    logic          expire;

    assign expire = (tick_q == TW'(INTERVAL - 1));

    // Free-running interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n)      tick_q <= '0;
        else if (expire) tick_q <= '0;
        else             tick_q <= tick_q + 1'b1;
    end

    // Pending flag: set on expiry, cleared when a refresh begins.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_o <= 1'b0;
        else if (expire)  pend_o <= 1'b1;
        else if (start_i) pend_o <= 1'b0;
    end

    // Row pointer: steps through the rows in order.
    always_ff @(posedge clk) begin
        if (!rst_n)      row_o <= '0;
        else if (done_i) row_o <= (row_o == AW'(ROWS - 1)) ? '0 : row_o + 1'b1;
    end

    // R9: the row pointer only ever moves to the next row.
    a_r9_row_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (row_o != $past(row_o)) |->
            (row_o == (($past(row_o) == AW'(ROWS - 1)) ? '0 : $past(row_o) + 1'b1)));
endmodule

// File: rtl/mux_dram_ctrl.sv
// DRAM-style array controller with a multiplexed row/column address.
// A row strobe loads a whole row into the buffer. Column strobes read or
// write the buffer. A close writes the buffer back. A refresh runs only
// while no row is open: one row is read and rewritten over two cycles.
// Assumes SIDE is a power of two and the host waits for ready_o before
// issuing a row strobe.
module mux_dram_ctrl
    import mdram_pkg::*;
#(
    parameter int SIDE             = 4,
    parameter int DATA_W           = 8,
    parameter int REFRESH_INTERVAL = 5000,
    localparam int AW              = $clog2(SIDE),
    localparam int ROW_W           = SIDE * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_i,
    input  logic              cas_i,
    input  logic              we_i,
    input  logic              pre_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic              err_o,
    output logic              ready_o,
    output logic [AW-1:0]     rfsh_row_o
);
    ctrl_state_e       state_q;
    logic [AW-1:0]     open_row_q;
    logic [ROW_W-1:0]  rf_tmp_q;
    logic              rf_pend;
    logic [ROW_W-1:0]  arr_rd_data;
    logic [ROW_W-1:0]  buf_row;
    logic [DATA_W-1:0] buf_col;
    logic              row_load, col_write, col_read, closing;
    logic              arr_we;
    logic [AW-1:0]     arr_rd_row, arr_wr_row;
    logic [ROW_W-1:0]  arr_wr_data;

    // Command decode against the current phase.
    assign row_load  = (state_q == ST_IDLE) && !rf_pend && ras_i;
    assign closing   = (state_q == ST_OPEN) && pre_i;
    assign col_write = (state_q == ST_OPEN) && !pre_i && cas_i && we_i;
    assign col_read  = (state_q == ST_OPEN) && !pre_i && cas_i && !we_i;
    assign ready_o   = (state_q == ST_OPEN) || ((state_q == ST_IDLE) && !rf_pend);

    // Array port steering: the refresh owns the ports during its two cycles.
    assign arr_rd_row  = (state_q == ST_RF_RD) ? rfsh_row_o : addr_i;
    assign arr_we      = closing || (state_q == ST_RF_WR);
    assign arr_wr_row  = (state_q == ST_RF_WR) ? rfsh_row_o : open_row_q;
    assign arr_wr_data = (state_q == ST_RF_WR) ? rf_tmp_q : buf_row;

    dram_cell_array #(.ROWS(SIDE), .ROW_W(ROW_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_row  (arr_rd_row),
        .rd_data (arr_rd_data),
        .wr_en   (arr_we),
        .wr_row  (arr_wr_row),
        .wr_data (arr_wr_data)
    );

    dram_row_buffer #(.COLS(SIDE), .W(DATA_W)) u_rowbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (row_load),
        .load_data (arr_rd_data),
        .col_we    (col_write),
        .col_sel   (addr_i),
        .col_wdata (wdata_i),
        .col_rdata (buf_col),
        .row_data  (buf_row)
    );

    dram_refresh_timer #(.INTERVAL(REFRESH_INTERVAL), .ROWS(SIDE)) u_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i ((state_q == ST_IDLE) && rf_pend),
        .done_i  (state_q == ST_RF_WR),
        .pend_o  (rf_pend),
        .row_o   (rfsh_row_o)
    );

    // Phase sequencer: a due refresh wins over a row strobe when closed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (rf_pend)    state_q <= ST_RF_RD;
                          else if (ras_i) state_q <= ST_OPEN;
                ST_OPEN:  if (pre_i)      state_q <= ST_IDLE;
                ST_RF_RD: state_q <= ST_RF_WR;
                ST_RF_WR: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Open-row register and refresh holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_row_q <= '0;
            rf_tmp_q   <= '0;
        end else begin
            if (row_load)              open_row_q <= addr_i;
            if (state_q == ST_RF_RD)   rf_tmp_q   <= arr_rd_data;
        end
    end

    // Read data, valid and error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
            err_o    <= 1'b0;
        end else begin
            rvalid_o <= col_read;
            err_o    <= cas_i && (state_q != ST_OPEN);
            if (col_read) rdata_o <= buf_col;
        end
    end

    // R6: a column strobe with no open row is flagged on the next cycle.
    a_r6_orphan_cas_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_i && state_q != ST_OPEN) |=> err_o);

    // R3: valid data only follows a read strobe into an open row.
    a_r3_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> ($past(state_q) == ST_OPEN && $past(cas_i) && !$past(we_i)));

    // R8: a refresh starts only from the closed phase.
    a_r8_refresh_from_closed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_RF_RD) |-> ($past(state_q) == ST_IDLE));

    // R10: no data or error follows a strobe that collided with a close.
    a_r10_close_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && pre_i && cas_i) |=> (!rvalid_o && !err_o));
endmodule

// File: tb/mux_dram_ctrl_test.sv
// Bench for mux_dram_ctrl: directed sequences plus a random command
// stream, checked every cycle against a behavioural model.
module mux_dram_ctrl_test;
    localparam int S  = 4;
    localparam int DW = 8;
    localparam int RI = 40;
    localparam int AW = $clog2(S);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras = 0, cas = 0, we = 0, pre = 0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic rvalid, err, ready;
    logic [AW-1:0] rfsh_row;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit cmp_on = 0;

    always #4 clk = ~clk; // 125 MHz

    mux_dram_ctrl #(.SIDE(S), .DATA_W(DW), .REFRESH_INTERVAL(RI)) uut (
        .clk(clk), .rst_n(rst_n), .ras_i(ras), .cas_i(cas), .we_i(we), .pre_i(pre),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
        .err_o(err), .ready_o(ready), .rfsh_row_o(rfsh_row)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // Behavioural model. Phases: 0 closed, 1 open, 2 refresh read, 3 refresh write.
    int m_mem [S*S];
    int m_buf [S];
    int m_tmp [S];
    int m_st, m_row, m_tmr, m_rr, m_rd, m_rv, m_err;
    bit m_pend;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            foreach (m_buf[i]) m_buf[i] = 0;
            m_st = 0; m_row = 0; m_tmr = 0; m_rr = 0; m_rd = 0; m_rv = 0; m_err = 0; m_pend = 0;
            cmp_on = 1;
        end else begin
            bit set_p, clr_p;
            set_p = (m_tmr == RI - 1);
            clr_p = 0;
            m_tmr = set_p ? 0 : m_tmr + 1;
            m_rv = 0;
            m_err = (cas && m_st != 1);
            case (m_st)
                0: if (m_pend) begin m_st = 2; clr_p = 1; end
                   else if (ras) begin
                       for (int c = 0; c < S; c++) m_buf[c] = m_mem[int'(addr)*S + c];
                       m_row = int'(addr); m_st = 1;
                   end
                1: if (pre) begin
                       for (int c = 0; c < S; c++) m_mem[m_row*S + c] = m_buf[c];
                       m_st = 0;
                   end else if (cas) begin
                       if (we) m_buf[int'(addr)] = int'(wdata);
                       else begin m_rd = m_buf[int'(addr)]; m_rv = 1; end
                   end
                2: begin
                       for (int c = 0; c < S; c++) m_tmp[c] = m_mem[m_rr*S + c];
                       m_st = 3;
                   end
                default: begin
                       for (int c = 0; c < S; c++) m_mem[m_rr*S + c] = m_tmp[c];
                       m_rr = (m_rr + 1) % S; m_st = 0;
                   end
            endcase
            if (set_p) m_pend = 1; else if (clr_p) m_pend = 0;
        end
    end

    // Every-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            check("R3 rdata", int'(rdata), m_rd);
            check("R3 rvalid", int'(rvalid), m_rv);
            check("R6 err", int'(err), m_err);
            check("R7 ready", int'(ready), int'(m_st == 1 || (m_st == 0 && !m_pend)));
            check("R9 rfsh_row", int'(rfsh_row), m_rr);
        end
    end

    // One command, held for one cycle from a falling edge.
    task automatic cmd(input bit r, input bit c, input bit w, input bit p,
                       input int a, input int d);
        @(negedge clk);
        ras = r; cas = c; we = w; pre = p; addr = AW'(a); wdata = DW'(d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cmd(0, 0, 0, 0, 0, 0);
    endtask

    task automatic open_row(input int r);
        cmd(0, 0, 0, 0, 0, 0);
        while (!ready) cmd(0, 0, 0, 0, 0, 0);
        cmd(1, 0, 0, 0, r, 0);
    endtask

    task automatic read_expect(input string req, input int c, input int exp);
        cmd(0, 1, 0, 0, c, 0);
        idle(1);
        check(req, int'(rdata), exp);
        check(req, int'(rvalid), 1);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int r0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset values.
        check("R1 rdata", int'(rdata), 0);
        check("R1 rvalid", int'(rvalid), 0);
        check("R1 err", int'(err), 0);
        check("R1 ready", int'(ready), 1);
        check("R1 rfsh_row", int'(rfsh_row), 0);

        // R6: column strobe with no row open.
        cmd(0, 1, 0, 0, 2, 0);
        idle(1);
        check("R6 err raised", int'(err), 1);
        check("R6 no rvalid", int'(rvalid), 0);
        idle(1);
        check("R6 err one cycle", int'(err), 0);

        // R1: fresh array reads zero.
        open_row(3);
        read_expect("R1 array cleared", 1, 0);
        cmd(0, 0, 0, 1, 0, 0);

        // R4/R5: fill every row through the buffer, close, read back.
        for (int r = 0; r < S; r++) begin
            open_row(r);
            for (int c = 0; c < S; c++) cmd(0, 1, 1, 0, c, 16 * r + c + 1);
            read_expect("R4 buffer write visible", 2, 16 * r + 3);
            cmd(0, 0, 0, 1, 0, 0);
        end
        for (int r = S - 1; r >= 0; r--) begin
            open_row(r);
            for (int c = 0; c < S; c++) read_expect("R5 write-back", c, 16 * r + c + 1);
            cmd(0, 0, 0, 1, 0, 0);
        end

        // R2: row strobe while open is ignored.
        open_row(1);
        cmd(1, 0, 0, 0, 2, 0);
        read_expect("R2 ras ignored while open", 0, 17);
        cmd(0, 0, 0, 1, 0, 0);

        // R5: close with no row open has no effect.
        cmd(0, 0, 0, 1, 0, 0);
        open_row(0);
        read_expect("R5 stray close", 3, 4);

        // R10: close and column write in one cycle.
        cmd(0, 1, 1, 1, 3, 8'hEE);
        idle(1);
        check("R10 no rvalid", int'(rvalid), 0);
        check("R10 no err", int'(err), 0);
        open_row(0);
        read_expect("R10 write dropped", 3, 4);

        // R8: hold the row open across several refresh intervals.
        r0 = int'(rfsh_row);
        idle(3 * RI);
        check("R8 ready held while open", int'(ready), 1);
        check("R8 no refresh while open", int'(rfsh_row), r0);
        cmd(0, 0, 0, 1, 0, 0);
        idle(1);
        check("R8 refresh after close", int'(ready), 0);
        idle(3);
        check("R9 row advanced", int'(rfsh_row), (r0 + 1) % S);
        check("R7 ready back", int'(ready), 1);

        // R7/R9: refreshes keep data and walk the rows.
        idle(5 * RI);
        open_row(2);
        read_expect("R7 data kept", 1, 34);
        cmd(0, 0, 0, 1, 0, 0);

        // Random stream against the model.
        for (int i = 0; i < 4000; i++) begin
            int k;
            k = int'($urandom_range(0, 9));
            cmd(k == 0, k >= 3 && k <= 7, k >= 6, k == 1 || k == 8,
                int'($urandom_range(0, S - 1)), int'($urandom_range(0, 255)));
        end
        idle(4);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule